// File: doc/BRIEF.md
# Heterogeneous Core Switch Controller

This controller decides which of five cores runs the single thread of a system where every core executes the same instruction set but offers a different balance of speed and power. Once per timeslice a one-cycle pulse presents a 16-bit throughput estimate and a 16-bit power estimate for each core. The controller excludes every core whose throughput is below half that of the reference (largest) core. Among the rest it picks the one with the highest throughput squared divided by power. The metric is compared by cross-multiplication, so no divider is needed. Ties go to the lower core index.

When the chosen core differs from the running one, a fixed migration sequence follows. The running core's pipeline is flushed. Its dirty first-level lines are written back to the shared second-level cache. The target is powered up and waits either for a fixed cycle count or for its ready signal. The target is then released, and finally the old core is powered down. The cores, the caches and the software that saves user state sit outside the block and are reached through request/acknowledge pairs.

States: IDLE waits for a timeslice pulse and captures the estimates (IDLE→EVAL). EVAL returns to IDLE when the pick equals the active core, and otherwise goes to FLUSH. FLUSH holds the flush request until it is acknowledged (→WBACK). WBACK holds the writeback request until it is acknowledged (→PWRUP). PWRUP leaves on target ready or on timer expiry (→HANDOFF). HANDOFF releases the target for one cycle (→PWRDN). PWRDN removes power from the old core (→IDLE).

Top module: `core_switch_ctrl`

## Requirements
- R1: After reset the active core is index 4. Only bit 4 of `core_pwr_en` and of `core_run` is set, and `flush_req`, `wb_req` and `switch_done` are low.
- R2: Estimates are captured only on a `slice_tick` pulse seen in IDLE. The decision is taken in the following cycle, and a migration's `flush_req` rises two cycles after the pulse.
- R3: Core i is a candidate only when 2·ips_i ≥ ips_4, where core 4 is the reference. A core at exactly half the reference is a candidate.
- R4: Among candidates the pick has the largest ips²/pwr, compared as ips_a²·pwr_b against ips_b²·pwr_a. On equality the lower index wins.
- R5: If the pick equals the active core, no request is raised, power and run enables are unchanged, and the controller is back in IDLE one cycle after the decision.
- R6: The migration order is fixed. `flush_req` is held until `flush_ack`. `wb_req` rises only after the flush is acknowledged and is held until `wb_ack`. Power-up starts only after the writeback is acknowledged.
- R7: Power-up lasts PWRUP_CYCLES cycles (default 64), or ends after d cycles when the target's `core_ready` is seen in power-up cycle d < PWRUP_CYCLES.
- R8: Outside power-up and handoff exactly one `core_pwr_en` bit is set. During power-up and handoff both the old and the target bits are set. After handoff only the target bit remains.
- R9: `core_run` is all zero during flush, writeback and power-up. It equals the target's one-hot during handoff. It is never set for an unpowered core.
- R10: `switch_done` is a one-cycle pulse in the handoff cycle. `active_id` changes to the target in the next cycle, and never at any other time.
- R11: A `slice_tick` that arrives while a migration is in progress has no effect: after the migration, no new request follows and `active_id` stays at the target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slice_tick | input | 1 | One-cycle timeslice boundary pulse |
| ips_est | input | 80 | Throughput estimates, core i in bits [16i+15:16i] |
| pwr_est | input | 80 | Power estimates, core i in bits [16i+15:16i] |
| flush_req | output | 1 | Pipeline flush request to the active core |
| flush_ack | input | 1 | Flush acknowledge |
| wb_req | output | 1 | First-level writeback request |
| wb_ack | input | 1 | Writeback acknowledge |
| core_ready | input | 5 | Per-core power-up ready |
| core_pwr_en | output | 5 | Per-core power enable |
| core_run | output | 5 | Per-core execution release |
| active_id | output | 3 | Index of the active core |
| switch_done | output | 1 | Pulse when the new core is released |

## Verification
The hardest situation to reach from the ports is a timeslice pulse that lands in the middle of power-up, carrying estimates that would clearly favour a third core. The bench injects such a pulse inside its power-up loop and then watches that no second flush request appears. The exact-half eligibility boundary and an exact metric tie are both built as directed estimate sets. Random slices vary the acknowledge delays, and the ready delay is chosen on either side of the timer limit.

// File: rtl/csw_pkg.sv
package csw_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_EVAL,
        ST_FLUSH,
        ST_WBACK,
        ST_PWRUP,
        ST_HANDOFF,
        ST_PWRDN
    } csw_state_e;

endpackage

// File: rtl/csw_selector.sv
module csw_selector #(
    parameter int N_CORES  = 5,
    parameter int EST_W    = 16,
    parameter int REF_CORE = N_CORES - 1,
    localparam int IDW     = $clog2(N_CORES),
    localparam int PW      = 3 * EST_W
) (
    input  logic [N_CORES*EST_W-1:0] ips_flat,
    input  logic [N_CORES*EST_W-1:0] pwr_flat,
    output logic [IDW-1:0]           pick
);

    logic [EST_W-1:0] ref_ips;
    assign ref_ips = ips_flat[REF_CORE*EST_W +: EST_W];

    // running best along the chain
    logic [EST_W-1:0] c_ips [0:N_CORES];
    logic [EST_W-1:0] c_pwr [0:N_CORES];
    logic [IDW-1:0]   c_idx [0:N_CORES];
    logic             c_vld [0:N_CORES];

    assign c_ips[0] = '0;
    assign c_pwr[0] = '0;
    assign c_idx[0] = '0;
    assign c_vld[0] = 1'b0;

    for (genvar g = 0; g < N_CORES; g++) begin : g_stage
        logic [EST_W-1:0] my_ips;
        logic [EST_W-1:0] my_pwr;
        logic             elig;
        logic [PW-1:0]    lhs;
        logic [PW-1:0]    rhs;
        logic             take;

        assign my_ips = ips_flat[g*EST_W +: EST_W];
        assign my_pwr = pwr_flat[g*EST_W +: EST_W];
        // performance floor: at least half the reference
        assign elig   = ({my_ips, 1'b0} >= {1'b0, ref_ips});
        // ips_g^2 * pwr_best  vs  ips_best^2 * pwr_g
        assign lhs    = PW'(my_ips) * PW'(my_ips) * PW'(c_pwr[g]);
        assign rhs    = PW'(c_ips[g]) * PW'(c_ips[g]) * PW'(my_pwr);
        // strict compare keeps the lower index on a tie
        assign take   = elig && (!c_vld[g] || (lhs > rhs));

        assign c_ips[g+1] = take ? my_ips : c_ips[g];
        assign c_pwr[g+1] = take ? my_pwr : c_pwr[g];
        assign c_idx[g+1] = take ? IDW'(g) : c_idx[g];
        assign c_vld[g+1] = take | c_vld[g];
    end

    assign pick = c_idx[N_CORES];

endmodule

// File: rtl/csw_wait_timer.sv
module csw_wait_timer #(
    parameter int LIMIT = 64,
    localparam int CW   = $clog2(LIMIT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run) begin
            cnt <= '0;
        end else if (!expired) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign expired = run && (cnt == CW'(LIMIT - 1));

    AST_WAIT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(LIMIT - 1)); // R7

    AST_WAIT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cnt == '0)); // R7

endmodule

// File: rtl/core_switch_ctrl.sv
module core_switch_ctrl
    import csw_pkg::*;
#(
    parameter int N_CORES      = 5,
    parameter int EST_W        = 16,
    parameter int REF_CORE     = N_CORES - 1,
    parameter int RESET_CORE   = N_CORES - 1,
    parameter int PWRUP_CYCLES = 64,
    localparam int IDW         = $clog2(N_CORES)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     slice_tick,
    input  logic [N_CORES*EST_W-1:0] ips_est,
    input  logic [N_CORES*EST_W-1:0] pwr_est,
    output logic                     flush_req,
    input  logic                     flush_ack,
    output logic                     wb_req,
    input  logic                     wb_ack,
    input  logic [N_CORES-1:0]       core_ready,
    output logic [N_CORES-1:0]       core_pwr_en,
    output logic [N_CORES-1:0]       core_run,
    output logic [IDW-1:0]           active_id,
    output logic                     switch_done
);

    csw_state_e state_q, state_d;

    logic [N_CORES*EST_W-1:0] ips_q;
    logic [N_CORES*EST_W-1:0] pwr_q;
    logic [IDW-1:0]           active_q;
    logic [IDW-1:0]           target_q;
    logic [IDW-1:0]           pick;
    logic                     wait_done;

    function automatic logic [N_CORES-1:0] one_hot(input logic [IDW-1:0] idx);
        logic [N_CORES-1:0] v;
        v = '0;
        v[idx] = 1'b1;
        return v;
    endfunction

    function automatic logic [EST_W-1:0] ips_of(input logic [N_CORES*EST_W-1:0] flat,
                                                input logic [IDW-1:0] idx);
        return flat[idx*EST_W +: EST_W];
    endfunction

    csw_selector #(
        .N_CORES  (N_CORES),
        .EST_W    (EST_W),
        .REF_CORE (REF_CORE)
    ) sel_i (
        .ips_flat (ips_q),
        .pwr_flat (pwr_q),
        .pick     (pick)
    );

    csw_wait_timer #(
        .LIMIT (PWRUP_CYCLES)
    ) tmr_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (state_q == ST_PWRUP),
        .expired (wait_done)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (slice_tick) state_d = ST_EVAL;
            ST_EVAL:    state_d = (pick == active_q) ? ST_IDLE : ST_FLUSH;
            ST_FLUSH:   if (flush_ack) state_d = ST_WBACK;
            ST_WBACK:   if (wb_ack) state_d = ST_PWRUP;
            ST_PWRUP:   if (core_ready[target_q] || wait_done) state_d = ST_HANDOFF;
            ST_HANDOFF: state_d = ST_PWRDN;
            ST_PWRDN:   state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // state register and captured data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            ips_q    <= '0;
            pwr_q    <= '0;
            active_q <= IDW'(RESET_CORE);
            target_q <= IDW'(RESET_CORE);
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && slice_tick) begin
                ips_q <= ips_est;
                pwr_q <= pwr_est;
            end
            if (state_q == ST_EVAL) begin
                target_q <= pick;
            end
            if (state_q == ST_HANDOFF) begin
                active_q <= target_q;
            end
        end
    end

    // outputs
    always_comb begin
        flush_req   = 1'b0;
        wb_req      = 1'b0;
        switch_done = 1'b0;
        core_pwr_en = one_hot(active_q);
        core_run    = one_hot(active_q);
        unique case (state_q)
            ST_IDLE, ST_EVAL, ST_PWRDN: ;
            ST_FLUSH: begin
                flush_req = 1'b1;
                core_run  = '0;
            end
            ST_WBACK: begin
                wb_req   = 1'b1;
                core_run = '0;
            end
            ST_PWRUP: begin
                core_pwr_en = one_hot(active_q) | one_hot(target_q);
                core_run    = '0;
            end
            ST_HANDOFF: begin
                core_pwr_en = one_hot(active_q) | one_hot(target_q);
                core_run    = one_hot(target_q);
                switch_done = 1'b1;
            end
            default: ;
        endcase
    end

    assign active_id = active_q;

    AST_RESET_CORE: assert property (@(posedge clk)
        $past(!rst_n) |-> (active_id == IDW'(RESET_CORE))); // R1

    AST_PICK_ELIGIBLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_EVAL) |->
            ({1'b0, ips_of(ips_q, pick), 1'b0} >= {2'b00, ips_of(ips_q, IDW'(REF_CORE))})); // R3

    AST_NO_SWITCH_SAME: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_EVAL && pick == active_q) |=> (state_q == ST_IDLE && !flush_req)); // R5

    AST_WB_AFTER_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wb_req) |-> $past(flush_ack)); // R6

    AST_FLUSH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_req && !flush_ack) |=> flush_req); // R6

    AST_ONE_POWERED: assert property (@(posedge clk) disable iff (!rst_n)
        ((core_run != '0) && !switch_done) |-> ($countones(core_pwr_en) == 1)); // R8

    AST_RUN_POWERED: assert property (@(posedge clk) disable iff (!rst_n)
        (core_run & ~core_pwr_en) == '0); // R9

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        switch_done |=> !switch_done); // R10

    AST_ACTIVE_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(active_id) |-> $past(switch_done)); // R10

    AST_TICK_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PWRUP && slice_tick && !wait_done && !core_ready[target_q])
            |=> (state_q == ST_PWRUP)); // R11

endmodule

// File: tb/core_switch_ctrl_tb_top.sv
`timescale 1ns/1ps
module core_switch_ctrl_tb_top;

    localparam int N   = 5;
    localparam int EW  = 16;
    localparam int PWU = 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          slice_tick = 1'b0;
    logic [N*EW-1:0] ips_est = '0;
    logic [N*EW-1:0] pwr_est = '0;
    logic          flush_req, wb_req, switch_done;
    logic          flush_ack = 1'b0;
    logic          wb_ack = 1'b0;
    logic [N-1:0]  core_ready = '0;
    logic [N-1:0]  core_pwr_en, core_run;
    logic [2:0]    active_id;

    int checks = 0;
    int fails  = 0;
    int active_m = 4;
    int ips [N];
    int pwr [N];

    always #2.5 clk = ~clk;

    core_switch_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .slice_tick(slice_tick),
        .ips_est(ips_est), .pwr_est(pwr_est),
        .flush_req(flush_req), .flush_ack(flush_ack),
        .wb_req(wb_req), .wb_ack(wb_ack),
        .core_ready(core_ready), .core_pwr_en(core_pwr_en),
        .core_run(core_run), .active_id(active_id),
        .switch_done(switch_done)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic [N-1:0] oh(input int i);
        logic [N-1:0] v;
        v = '0;
        v[i] = 1'b1;
        return v;
    endfunction

    // R3 floor, R4 metric with lower index winning ties
    function automatic int exp_pick();
        int best;
        best = -1;
        for (int i = 0; i < N; i++) begin
            if (2 * ips[i] >= ips[N-1]) begin
                if (best < 0) best = i;
                else if (longint'(ips[i]) * longint'(ips[i]) * longint'(pwr[best]) >
                         longint'(ips[best]) * longint'(ips[best]) * longint'(pwr[i]))
                    best = i;
            end
        end
        return best;
    endfunction

    task automatic drive_est();
        for (int i = 0; i < N; i++) begin
            ips_est[i*EW +: EW] = EW'(ips[i]);
            pwr_est[i*EW +: EW] = EW'(pwr[i]);
        end
    endtask

    task automatic run_slice(input int ready_delay, input bit inject);
        int expc, old, n, exp_n, other;
        expc = exp_pick();
        old  = active_m;
        @(negedge clk);
        drive_est();
        slice_tick = 1'b1;
        @(negedge clk);
        slice_tick = 1'b0;
        // EVAL now
        @(negedge clk);
        if (expc == old) begin
            chk(flush_req == 1'b0, "R5", "flush_req on same core", flush_req, 0);
            chk(active_id == 3'(old), "R5", "active_id", active_id, old);
            chk(core_pwr_en == oh(old), "R5", "pwr_en", core_pwr_en, oh(old));
            @(negedge clk);
            chk(flush_req == 1'b0 && wb_req == 1'b0, "R5", "late request", flush_req, 0);
        end else begin
            chk(flush_req == 1'b1, "R2", "flush_req two cycles after tick", flush_req, 1);
            chk(core_run == '0, "R9", "run during flush", core_run, 0);
            chk(core_pwr_en == oh(old), "R8", "pwr_en during flush", core_pwr_en, oh(old));
            for (int k = 0; k < int'($urandom_range(0, 2)); k++) begin
                @(negedge clk);
                chk(flush_req == 1'b1 && wb_req == 1'b0, "R6", "flush held", flush_req, 1);
            end
            flush_ack = 1'b1;
            @(negedge clk);
            flush_ack = 1'b0;
            chk(wb_req == 1'b1 && flush_req == 1'b0, "R6", "wb_req after flush ack", wb_req, 1);
            chk(core_pwr_en == oh(old), "R8", "pwr_en during writeback", core_pwr_en, oh(old));
            for (int k = 0; k < int'($urandom_range(0, 2)); k++) begin
                @(negedge clk);
                chk(wb_req == 1'b1 && core_pwr_en == oh(old), "R6", "wb held", wb_req, 1);
            end
            wb_ack = 1'b1;
            @(negedge clk);
            wb_ack = 1'b0;
            n = 0;
            while (switch_done == 1'b0 && n < 2 * PWU + 10) begin
                n++;
                if (n == 1)
                    chk(core_pwr_en == (oh(old) | oh(expc)), "R8", "both powered",
                        core_pwr_en, oh(old) | oh(expc));
                if (core_run != '0)
                    chk(1'b0, "R9", "run during power-up", core_run, 0);
                if (inject && n == 2) begin
                    other = (expc + 1) % N;
                    if (other == old) other = (other + 1) % N;
                    for (int i = 0; i < N; i++) begin
                        ips_est[i*EW +: EW] = 16'd1000;
                        pwr_est[i*EW +: EW] = 16'd1000;
                    end
                    ips_est[other*EW +: EW] = 16'd60000;
                    pwr_est[other*EW +: EW] = 16'd1;
                    slice_tick = 1'b1;
                end
                if (ready_delay > 0 && n == ready_delay) core_ready[expc] = 1'b1;
                @(negedge clk);
                slice_tick = 1'b0;
            end
            exp_n = (ready_delay > 0 && ready_delay < PWU) ? ready_delay : PWU;
            chk(switch_done == 1'b1, "R10", "done at handoff", switch_done, 1);
            chk(n == exp_n, "R7", "power-up cycles", n, exp_n);
            chk(core_run == oh(expc), "R9", "target released", core_run, oh(expc));
            chk(core_pwr_en == (oh(old) | oh(expc)), "R8", "pwr at handoff",
                core_pwr_en, oh(old) | oh(expc));
            chk(active_id == 3'(old), "R10", "active before update", active_id, old);
            @(negedge clk);
            core_ready = '0;
            chk(switch_done == 1'b0, "R10", "done is one cycle", switch_done, 0);
            chk(active_id == 3'(expc), "R4", "new active core", active_id, expc);
            chk(core_pwr_en == oh(expc), "R8", "old core powered down", core_pwr_en, oh(expc));
            active_m = expc;
            if (inject) begin
                for (int k = 0; k < 4; k++) begin
                    @(negedge clk);
                    chk(flush_req == 1'b0 && active_id == 3'(expc), "R11",
                        "tick during migration ignored", active_id, expc);
                end
            end
        end
    endtask

    initial begin
        void'($urandom(32'd2718));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(active_id == 3'd4, "R1", "reset active", active_id, 4);
        chk(core_pwr_en == 5'b10000, "R1", "reset pwr_en", core_pwr_en, 16);
        chk(core_run == 5'b10000, "R1", "reset run", core_run, 16);
        chk(!flush_req && !wb_req && !switch_done, "R1", "reset requests", flush_req, 0);

        // R5: reference core is best -> stays
        for (int i = 0; i < N; i++) begin ips[i] = 1000; pwr[i] = 1000; end
        ips[4] = 2000; pwr[4] = 100;
        run_slice(0, 1'b0);

        // R2: tick held low -> nothing happens
        repeat (5) @(negedge clk);
        chk(!flush_req && active_id == 3'd4, "R2", "no tick no action", active_id, 4);

        // R4 tie: all equal -> core 0; R7 timer expiry (no ready)
        for (int i = 0; i < N; i++) begin ips[i] = 1000; pwr[i] = 1000; end
        chk(exp_pick() == 0, "R4", "tie model", exp_pick(), 0);
        run_slice(0, 1'b0);

        // R3 boundary: core0 too slow, core1 exactly half and ties ref -> core1; R11 inject
        ips[0] = 100;  pwr[0] = 1;
        ips[1] = 500;  pwr[1] = 250;
        ips[2] = 499;  pwr[2] = 1;
        ips[3] = 1000; pwr[3] = 2000;
        ips[4] = 1000; pwr[4] = 1000;
        chk(exp_pick() == 1, "R3", "floor model", exp_pick(), 1);
        run_slice(5, 1'b1);

        // random slices
        for (int s = 0; s < 30; s++) begin
            for (int i = 0; i < N; i++) begin
                ips[i] = int'($urandom_range(1, 65535));
                pwr[i] = int'($urandom_range(1, 65535));
            end
            if (s % 5 == 0) ips[4] = int'($urandom_range(1, 4000));
            run_slice(int'($urandom_range(0, 80)), 1'(s % 7 == 3));
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule